// File: doc/BRIEF.md
# Sandcastle Blanking Generator with Vertical Scan Guard

The block drives a composite blanking line that carries three levels: idle, blanking and a clamp key. Each scan line starts with a horizontal blanking interval. A clamp key pulse follows it a programmable number of clocks later. Each frame starts with a vertical blanking interval that lasts a programmable number of lines. The level goes out as a two-bit code, and a pad stage downstream turns that code into analog levels.

A short guard window sits inside each vertical blanking interval. It starts on the second blanking line and spans a parameterised number of lines. During the window the block stops driving the shared line and watches a feedback input that carries the vertical flyback pulse. If the window closes without a valid flyback, the block concludes that vertical scan has stopped. It then keeps the line blanked for the whole frame and raises a status flag. A later window that does see flyback returns the block to normal output. After reset the block starts in the blanked, scan-lost state and stays there until the first guard check succeeds.

Top module: `sc_blank_guard`

## Requirements
- R1: During and right after reset, `level` is 01, `pad_oe` is 1 and `vert_loss` is 1.
- R2: `level` is coded 00 idle, 01 blanking, 10 clamp key, and never takes 11. The clock after a sampled `line_stb` is line position 0. Positions 0 to HB_CLKS-1 are horizontal blanking (01).
- R3: Positions CLAMP_AT to CLAMP_AT+CLAMP_CLKS-1 of every line outside the guard window show the clamp key (10). The clamp key takes priority over any blanking.
- R4: A `frame_stb`, which is always given together with `line_stb`, begins vertical blanking. Vertical blanking covers that line and the next VB_LINES-1 lines. Within it, every non-clamp clock outside the guard window is 01.
- R5: The guard window covers vertical blanking lines 1 to GUARD_LINES, counting the frame-start line as 0. Inside the window `pad_oe` is 0 and `level` is 00. Everywhere else `pad_oe` is 1.
- R6: Flyback counts as seen when `flyback_in` is high on 2 consecutive clocks, both inside the window. When such a window closes, `vert_loss` clears on the clock that ends the window. Isolated single-clock pulses do not count.
- R7: While `vert_loss` is 1, every clock outside the guard window and the clamp key shows 01.
- R8: A window that closes without seeing flyback sets `vert_loss` to 1. It then stays at 1 until a later window sees flyback.
- R9: `flyback_in` has no effect outside the guard window.
- R10: A `frame_stb` that arrives inside the guard window cancels that window without a verdict, so `vert_loss` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-clock pulse at the start of each scan line |
| frame_stb | input | 1 | One-clock pulse at the start of a frame, given together with line_stb |
| flyback_in | input | 1 | Vertical flyback feedback sampled from the pad |
| level | output | 2 | Level code: 00 idle, 01 blanking, 10 clamp key |
| pad_oe | output | 1 | Pad drive enable; 0 during the guard window |
| vert_loss | output | 1 | 1 while vertical scan is considered lost and blanking is forced |

## Verification
The assertions assume three things about the inputs: `frame_stb` only arrives together with `line_stb`, lines are longer than the clamp pulse end, and a frame is longer than VB_LINES lines, except where a frame is deliberately cut short inside the window. The stimulus builds every frame from whole lines of fixed length, with a line strobe on the first clock of each line. The frame strobe sits on the first line of a frame. Only one short frame ends inside the window, to exercise the cancel case. Flyback pulses are placed at chosen positions: a two-clock pulse inside the window, isolated single-clock pulses inside it, and pulses outside it. This gives both outcomes of the guard check from both starting states.

// File: rtl/sc_pkg.sv
// Shared types for the sandcastle blanking generator.
// Assumes nothing beyond a two-bit level code on the pad.
package sc_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE  = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_CLAMP = 2'b10
    } sc_level_e;
endpackage

// File: rtl/sc_line_timer.sv
// Tracks the clock position inside the current line and decodes the
// horizontal blanking and clamp key intervals.
// Assumes CLAMP_AT >= HB_CLKS and lines longer than CLAMP_AT+CLAMP_CLKS.
module sc_line_timer #(
    parameter int HB_CLKS    = 4,
    parameter int CLAMP_AT   = 6,
    parameter int CLAMP_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    output logic hblank,
    output logic clamp
);
    localparam int POS_MAX = CLAMP_AT + CLAMP_CLKS;
    localparam int POS_W   = $clog2(POS_MAX + 1);

    logic [POS_W-1:0] pos;

    // Position counter: restarts on a line strobe, saturates past the clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= POS_W'(POS_MAX);
        else if (line_stb)
            pos <= '0;
        else if (pos != POS_W'(POS_MAX))
            pos <= pos + 1'b1;
    end

    // Interval decode from the position.
    always_comb begin
        hblank = (int'(pos) < HB_CLKS);
        clamp  = (int'(pos) >= CLAMP_AT) && (int'(pos) < POS_MAX);
    end
endmodule

// File: rtl/sc_frame_timer.sv
// Counts lines of vertical blanking and decodes the guard window.
// Assumes frame_stb coincides with line_stb and VB_LINES > GUARD_LINES + 1.
module sc_frame_timer #(
    parameter int VB_LINES    = 6,
    parameter int GUARD_LINES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic frame_stb,
    output logic vblank,
    output logic guard,
    output logic guard_end
);
    localparam int VL_W = $clog2(VB_LINES + 1);

    logic [VL_W-1:0] vline;
    logic            vb_q;

    // Line counter within vertical blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vline <= '0;
            vb_q  <= 1'b0;
        end else if (frame_stb) begin
            vline <= '0;
            vb_q  <= 1'b1;
        end else if (line_stb && vb_q) begin
            vline <= vline + 1'b1;
            if (int'(vline) + 1 == VB_LINES)
                vb_q <= 1'b0;
        end
    end

    // Window decode and end-of-window strobe.
    always_comb begin
        vblank    = vb_q;
        guard     = vb_q && (vline >= VL_W'(1)) && (int'(vline) <= GUARD_LINES);
        guard_end = guard && line_stb && !frame_stb && (int'(vline) == GUARD_LINES);
    end
endmodule

// File: rtl/sc_guard_check.sv
// Looks for two consecutive high flyback samples inside the guard window
// and keeps the scan-lost flag, which is updated only when a window closes.
// Assumes guard and guard_end come from the frame timer of the same clock.
module sc_guard_check (
    input  logic clk,
    input  logic rst_n,
    input  logic guard,
    input  logic guard_end,
    input  logic frame_stb,
    input  logic flyback_in,
    output logic vert_loss
);
    logic fb_q;
    logic seen;
    logic pair_now;

    // A valid pair: this sample and the previous one both high, in window.
    always_comb pair_now = guard && flyback_in && fb_q;

    // Sample history and window result bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q      <= 1'b0;
            seen      <= 1'b0;
            vert_loss <= 1'b1;
        end else begin
            fb_q <= guard && flyback_in;
            if (guard_end)
                vert_loss <= !(seen || pair_now);
            if (frame_stb || guard_end)
                seen <= 1'b0;
            else if (pair_now)
                seen <= 1'b1;
        end
    end
endmodule

// File: rtl/sc_blank_guard.sv
// Top: composite sandcastle level generator with a vertical scan guard.
// Assumes frame_stb only arrives together with line_stb.
module sc_blank_guard #(
    parameter int HB_CLKS     = 4,
    parameter int CLAMP_AT    = 6,
    parameter int CLAMP_CLKS  = 3,
    parameter int VB_LINES    = 6,
    parameter int GUARD_LINES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       frame_stb,
    input  logic       flyback_in,
    output logic [1:0] level,
    output logic       pad_oe,
    output logic       vert_loss
);
    import sc_pkg::*;

    logic hblank, clamp, vblank, guard, guard_end;
    sc_level_e lvl;

    sc_line_timer #(
        .HB_CLKS(HB_CLKS), .CLAMP_AT(CLAMP_AT), .CLAMP_CLKS(CLAMP_CLKS)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .hblank(hblank), .clamp(clamp)
    );

    sc_frame_timer #(
        .VB_LINES(VB_LINES), .GUARD_LINES(GUARD_LINES)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
        .vblank(vblank), .guard(guard), .guard_end(guard_end)
    );

    sc_guard_check u_check (
        .clk(clk), .rst_n(rst_n), .guard(guard), .guard_end(guard_end),
        .frame_stb(frame_stb), .flyback_in(flyback_in), .vert_loss(vert_loss)
    );

    // Level priority: released pad, clamp key, any blanking, idle.
    always_comb begin
        if (guard)
            lvl = LVL_IDLE;
        else if (clamp)
            lvl = LVL_CLAMP;
        else if (vert_loss || vblank || hblank)
            lvl = LVL_BLANK;
        else
            lvl = LVL_IDLE;
        level  = lvl;
        pad_oe = !guard;
    end
endmodule

// File: rtl/sc_blank_guard_chk.sv
// Checker for sc_blank_guard, observing its ports only.
module sc_blank_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] level,
    input logic       pad_oe,
    input logic       vert_loss
);
    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        level != 2'b11); // R2
    AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> level == 2'b00); // R5
    AST_LOSS_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vert_loss && pad_oe && level != 2'b10) |-> level == 2'b01); // R7
    AST_LOSS_CLEAR_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vert_loss) |-> $past(!pad_oe)); // R6
    AST_LOSS_SET_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vert_loss) |-> $past(!pad_oe)); // R8
    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && $past(pad_oe)) |-> $stable(vert_loss)); // R9
endmodule

bind sc_blank_guard sc_blank_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .level(level), .pad_oe(pad_oe), .vert_loss(vert_loss)
);

// File: tb/sim_sc_blank_guard.sv
module sim_sc_blank_guard;
    localparam int HB = 4, CA = 6, CW = 3, VB = 6, GL = 3;
    localparam int LINE_LEN = 20;
    localparam int POS_MAX = CA + CW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic line_stb = 1'b0, frame_stb = 1'b0, flyback_in = 1'b0;
    logic [1:0] level;
    logic pad_oe, vert_loss;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sc_blank_guard #(.HB_CLKS(HB), .CLAMP_AT(CA), .CLAMP_CLKS(CW),
                     .VB_LINES(VB), .GUARD_LINES(GL)) u0 (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
        .flyback_in(flyback_in), .level(level), .pad_oe(pad_oe), .vert_loss(vert_loss)
    );

    // Scoreboard: expected {level, pad_oe, vert_loss} plus requirement tags.
    logic [3:0] exp_q[$];
    string lvl_tag_q[$];
    string loss_tag_q[$];
    string scen_tag = "R8";

    // Spec model state.
    int m_pos = POS_MAX, m_vline = 0;
    bit m_vb = 0, m_loss = 1, m_fbq = 0, m_seen = 0;

    task automatic step(input bit ls, input bit fs, input bit fly);
        bit g, pair, wend, g2, hb, cl;
        logic [1:0] el;
        string t;
        line_stb = ls; frame_stb = fs; flyback_in = fly;
        g    = m_vb && m_vline >= 1 && m_vline <= GL;
        pair = g && fly && m_fbq;
        wend = g && ls && !fs && m_vline == GL;
        if (wend) m_loss = !(m_seen || pair);
        m_seen = (fs || wend) ? 1'b0 : (m_seen || pair);
        m_fbq  = g && fly;
        if (ls) m_pos = 0; else if (m_pos < POS_MAX) m_pos++;
        if (fs) begin m_vline = 0; m_vb = 1; end
        else if (ls && m_vb) begin
            if (m_vline + 1 == VB) m_vb = 0;
            m_vline++;
        end
        g2 = m_vb && m_vline >= 1 && m_vline <= GL;
        hb = m_pos < HB;
        cl = m_pos >= CA && m_pos < POS_MAX;
        if (g2)                        begin el = 2'b00; t = "R5"; end
        else if (cl)                   begin el = 2'b10; t = "R3"; end
        else if (m_loss)               begin el = 2'b01; t = "R7"; end
        else if (m_vb)                 begin el = 2'b01; t = "R4"; end
        else if (hb)                   begin el = 2'b01; t = "R2"; end
        else                           begin el = 2'b00; t = "R2"; end
        exp_q.push_back({el, !g2, m_loss});
        lvl_tag_q.push_back(t);
        loss_tag_q.push_back(scen_tag);
        @(negedge clk);
    endtask

    // mode 0 none, 1 two-clock pulse at p0, 2 isolated single pulses from p0
    task automatic run_line(input bit fs, input int mode, input int p0);
        for (int p = 0; p < LINE_LEN; p++) begin
            bit f;
            f = (mode == 1 && (p == p0 || p == p0 + 1)) ||
                (mode == 2 && p >= p0 && ((p - p0) % 2 == 0));
            step(p == 0, fs && p == 0, f);
        end
    endtask

    task automatic run_frame(input int nlines, input int fly_line,
                             input int mode, input int p0);
        for (int l = 0; l < nlines; l++)
            run_line(l == 0, (l == fly_line) ? mode : 0, p0);
    endtask

    // Monitor: compares outputs after each clock edge.
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string tl, tv;
                e = exp_q.pop_front(); tl = lvl_tag_q.pop_front(); tv = loss_tag_q.pop_front();
                n_tests++;
                if (level !== e[3:2] || pad_oe !== e[1]) begin
                    n_fail++;
                    $display("FAIL %s level/pad_oe: got %b/%b expected %b/%b",
                             tl, level, pad_oe, e[3:2], e[1]);
                end
                n_tests++;
                if (vert_loss !== e[0]) begin
                    n_fail++;
                    $display("FAIL %s vert_loss: got %b expected %b", tv, vert_loss, e[0]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if (level !== 2'b01 || pad_oe !== 1'b1 || vert_loss !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset: got %b/%b/%b expected 01/1/1", level, pad_oe, vert_loss);
        end
        rst_n = 1'b1;
        scen_tag = "R8"; run_frame(10, -1, 0, 0);  // no flyback: stays lost
        scen_tag = "R6"; run_frame(10, 2, 1, 5);   // pair in window: clears
        scen_tag = "R9"; run_frame(10, 7, 1, 5);   // flyback outside only: lost
        scen_tag = "R9"; run_frame(10, 0, 1, 12);  // flyback on line 0, before window
        scen_tag = "R6"; run_frame(10, 2, 2, 3);   // single pulses: stays lost
        scen_tag = "R6"; run_frame(10, 3, 1, 10);  // pair on last window line
        scen_tag = "R10"; run_frame(2, -1, 0, 0);  // frame cut inside window
        scen_tag = "R10"; run_frame(10, 1, 1, 3);  // good frame, stays clear
        scen_tag = "R8"; run_frame(10, -1, 0, 0);  // loss returns
        run_line(0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule